// File: doc/BRIEF.md
# I2C Bus Recovery Controller

This block returns a hung two-wire bus to idle when it is asked to. A request on `start_i` makes it let go of both lines and wait a short settle window, then sample the clock line. If the clock line is low, a target device is holding it, and nothing this block can do will help, so it ends at once with an error code. If the clock line is high but the data line is held low, the block clocks the bus. Each pulse pulls the clock low for a fixed number of timing ticks and then releases it. A target that stretches the clock delays the high phase, just as it would during normal byte traffic. The data line is sampled before every pulse. The run ends with success as soon as the data line reads high, and with an error once the pulse budget is spent.

The block uses the same open-drain convention as the byte engine next to it: an output enable of 1 pulls a line low, and 0 leaves it to the pull-up. All waits count an external tick strobe, so the bus speed is set outside this block. The result appears on a one-cycle `done_o` pulse. It carries a status code and the number of clock pulses actually issued, and both stay readable until the next accepted request.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o` and `done_o` are 0, `status_o` is 0 and `pulses_o` is 0.
- R2: An accepted request keeps both lines released (`scl_oe_o` = 0, `sda_oe_o` = 0) for at least SETTLE_TICKS ticks before the first clock pulse. `sda_oe_o` is never asserted.
- R3: If `scl_i` reads 0 at the end of the settle window, the run ends with `status_o` = 1 (clock held), `pulses_o` = 0, and no clock pulse issued.
- R4: If `sda_i` reads 1 at the first check, the run ends with `status_o` = 0 (bus free) and `pulses_o` = 0.
- R5: If the data line is freed after k pulses, with k at most MAX_PULSES, the run ends with `status_o` = 0 and `pulses_o` = k, and exactly k pulses appear on `scl_oe_o`.
- R6: If `sda_i` is still 0 after MAX_PULSES pulses (default 9), the run ends with `status_o` = 2 (data held) and `pulses_o` = MAX_PULSES. No further pulse is issued.
- R7: Each pulse asserts `scl_oe_o` for HALF_TICKS ticks. After release, the block waits for `scl_i` to read 1 and then holds the high phase for HALF_TICKS ticks before the next check. A target that stretches the clock for S cycles lengthens the low time seen on the line by S cycles.
- R8: If `scl_i` does not rise within STRETCH_TICKS ticks after a release, the run ends with `status_o` = 3 (stretch timeout). `pulses_o` then counts the pulses issued so far.
- R9: A `start_i` assertion while `busy_o` = 1 is ignored. The run in progress is neither restarted nor recounted.
- R10: `done_o` is high for exactly one cycle per run. `status_o` and `pulses_o` hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timing strobe; every wait counts these |
| start_i | input | 1 | Recovery request, taken only when idle |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low; kept at 0 |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| status_o | output | 2 | 0 bus free, 1 clock held, 2 data held, 3 stretch timeout |
| pulses_o | output | $clog2(MAX_PULSES+1) | Clock pulses issued in the last run |

## Verification
A wrong state or a wrong timer value shows up in the pulse train within one pulse period. Too many or too few `scl_oe_o` pulses appear, a low phase has the wrong width, or a pulse lands inside the settle window. The pulse counter is only visible at the end of a run, so a miscount shows as a `pulses_o` value that disagrees with the pulses the bench counted on the line. A broken idle guard in the request path shows as a second `done_o` strobe or a count that starts over.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [2:0] {
        RS_IDLE   = 3'd0,
        RS_SETTLE = 3'd1,
        RS_CHECK  = 3'd2,
        RS_LOW    = 3'd3,
        RS_RISE   = 3'd4,
        RS_HIGH   = 3'd5,
        RS_FIN    = 3'd6
    } rec_state_e;

    typedef enum logic [1:0] {
        REC_OK        = 2'd0,
        REC_SCL_HELD  = 2'd1,
        REC_SDA_HELD  = 2'd2,
        REC_STRETCH   = 2'd3
    } rec_status_e;

    // End-of-run record carried from the controller to the result register
    typedef struct packed {
        logic        valid;
        rec_status_e code;
    } rec_result_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/busrec_timer.sv
module busrec_timer #(
    parameter int TMR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [TMR_W-1:0] cnt_q;

    // load_val_i is the tick count minus one; expiry lands on the last tick
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/busrec_pulse_ctr.sv
module busrec_pulse_ctr #(
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_max_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PULSES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o  = cnt_q;
    assign at_max_o = (cnt_q == CAP);
endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
    import busrec_pkg::*;
#(
    parameter int HALF_TICKS    = 4,
    parameter int SETTLE_TICKS  = 2,
    parameter int STRETCH_TICKS = 16,
    parameter int TMR_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             tmr_expired_i,
    input  logic             at_max_i,
    output rec_state_e       state_o,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output rec_result_t      result_o
);
    localparam logic [TMR_W-1:0] SETTLE_LD  = TMR_W'(SETTLE_TICKS - 1);
    localparam logic [TMR_W-1:0] HALF_LD    = TMR_W'(HALF_TICKS - 1);
    localparam logic [TMR_W-1:0] STRETCH_LD = TMR_W'(STRETCH_TICKS - 1);

    rec_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d         = state_q;
        tmr_load_o      = 1'b0;
        tmr_val_o       = '0;
        cnt_clr_o       = 1'b0;
        cnt_inc_o       = 1'b0;
        result_o.valid  = 1'b0;
        result_o.code   = REC_OK;
        unique case (state_q)
            RS_IDLE: begin
                if (start_i) begin
                    state_d    = RS_SETTLE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SETTLE_LD;
                    cnt_clr_o  = 1'b1;
                end
            end
            RS_SETTLE: begin
                if (tmr_expired_i) begin
                    if (!scl_i) begin
                        state_d        = RS_FIN;
                        result_o.valid = 1'b1;
                        result_o.code  = REC_SCL_HELD;
                    end else begin
                        state_d = RS_CHECK;
                    end
                end
            end
            RS_CHECK: begin
                if (sda_i) begin
                    state_d        = RS_FIN;
                    result_o.valid = 1'b1;
                    result_o.code  = REC_OK;
                end else if (at_max_i) begin
                    state_d        = RS_FIN;
                    result_o.valid = 1'b1;
                    result_o.code  = REC_SDA_HELD;
                end else begin
                    state_d    = RS_LOW;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HALF_LD;
                    cnt_inc_o  = 1'b1;
                end
            end
            RS_LOW: begin
                if (tmr_expired_i) begin
                    state_d    = RS_RISE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = STRETCH_LD;
                end
            end
            RS_RISE: begin
                if (scl_i) begin
                    state_d    = RS_HIGH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HALF_LD;
                end else if (tmr_expired_i) begin
                    state_d        = RS_FIN;
                    result_o.valid = 1'b1;
                    result_o.code  = REC_STRETCH;
                end
            end
            RS_HIGH: begin
                if (tmr_expired_i) state_d = RS_CHECK;
            end
            RS_FIN: begin
                state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import busrec_pkg::*;
#(
    parameter int MAX_PULSES    = 9,
    parameter int HALF_TICKS    = 4,
    parameter int SETTLE_TICKS  = 2,
    parameter int STRETCH_TICKS = 16,
    localparam int CNT_W = $clog2(MAX_PULSES + 1),
    localparam int TMR_W = $clog2(max3(HALF_TICKS, SETTLE_TICKS, STRETCH_TICKS) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [CNT_W-1:0] pulses_o
);
    rec_state_e       state;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic             cnt_clr, cnt_inc, at_max;
    logic [CNT_W-1:0] count;
    rec_result_t      result;
    rec_status_e      status_q;
    logic [CNT_W-1:0] pulses_q;

    busrec_ctrl #(
        .HALF_TICKS   (HALF_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .STRETCH_TICKS(STRETCH_TICKS),
        .TMR_W        (TMR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .tmr_expired_i(tmr_expired),
        .at_max_i     (at_max),
        .state_o      (state),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .cnt_clr_o    (cnt_clr),
        .cnt_inc_o    (cnt_inc),
        .result_o     (result)
    );

    busrec_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_expired)
    );

    busrec_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_pulses (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (count),
        .at_max_o(at_max)
    );

    // Result register: captured on the way into the final state
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= REC_OK;
            pulses_q <= '0;
        end else if (result.valid) begin
            status_q <= result.code;
            pulses_q <= count;
        end
    end

    assign scl_oe_o = (state == RS_LOW);
    assign sda_oe_o = 1'b0;
    assign busy_o   = (state != RS_IDLE);
    assign done_o   = (state == RS_FIN);
    assign status_o = status_q;
    assign pulses_o = pulses_q;
endmodule

// File: rtl/busrec_checker.sv
module busrec_checker #(
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             sda_i,
    input logic             scl_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [1:0]       status_o,
    input logic [CNT_W-1:0] pulses_o
);
    p_clock_held_no_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == 2'd1) |-> (pulses_o == '0));

    p_ok_after_sda_high_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == 2'd0) |-> $past(sda_i));

    p_pulse_cap_r6: assert property (@(posedge clk) disable iff (rst)
        pulses_o <= CNT_W'(MAX_PULSES));

    p_data_held_full_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == 2'd2) |-> (pulses_o == CNT_W'(MAX_PULSES)));

    p_drive_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
        scl_oe_o |-> busy_o);

    p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=> busy_o);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(status_o) && $stable(pulses_o)));
endmodule

bind i2c_bus_recover busrec_checker #(
    .MAX_PULSES(MAX_PULSES),
    .CNT_W     (CNT_W)
) u_busrec_checker (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sda_i   (sda_i),
    .scl_oe_o(scl_oe_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .status_o(status_o),
    .pulses_o(pulses_o)
);

// File: tb/tb_i2c_bus_recover.sv
`timescale 1ns/1ps
module tb_i2c_bus_recover;
    localparam int MAXP    = 9;
    localparam int HALF    = 4;
    localparam int SETTLE  = 2;
    localparam int STRETCH = 16;
    localparam int CW      = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b1;
    logic start_i = 1'b0;
    logic scl_i, sda_i;
    logic scl_oe_o, sda_oe_o, busy_o, done_o;
    logic [1:0] status_o;
    logic [CW-1:0] pulses_o;

    always #2 clk = ~clk;

    i2c_bus_recover #(
        .MAX_PULSES(MAXP), .HALF_TICKS(HALF),
        .SETTLE_TICKS(SETTLE), .STRETCH_TICKS(STRETCH)
    ) dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .pulses_o(pulses_o)
    );

    // Target model and line monitor
    int  release_after = 0;
    int  stretch_len   = 0;
    bit  scl_stuck     = 1'b0;
    int  tick_div      = 1;
    int  tick_cnt      = 0;
    int  hold_cnt      = 0;
    int  rises         = 0;
    bit  sda_hold      = 1'b0;
    bit  prev_scl      = 1'b1;
    bit  prev_oe       = 1'b0;
    int  obs_pulses    = 0;
    int  oe_run = 0,  last_oe_w  = 0;
    int  low_run = 0, last_low_w = 0;
    int  sda_oe_seen   = 0;
    int  since_start   = 0;
    int  first_oe_at   = -1;
    int  done_cnt      = 0;
    int  done_run = 0, max_done_run = 0;

    assign scl_i = !scl_oe_o && (hold_cnt == 0) && !scl_stuck;
    assign sda_i = !sda_oe_o && !sda_hold;

    always @(negedge clk) begin
        // observe
        since_start++;
        if (sda_oe_o) sda_oe_seen++;
        if (scl_oe_o && !prev_oe) begin
            obs_pulses++;
            if (first_oe_at < 0) first_oe_at = since_start;
        end
        if (scl_oe_o) oe_run++;
        else if (oe_run > 0) begin last_oe_w = oe_run; oe_run = 0; end
        if (!scl_i) low_run++;
        else if (low_run > 0) begin last_low_w = low_run; low_run = 0; end
        if (done_o) begin
            done_run++;
            if (done_run == 1) done_cnt++;
            if (done_run > max_done_run) max_done_run = done_run;
        end else done_run = 0;
        if (scl_i && !prev_scl) begin
            rises++;
            if (rises >= release_after) sda_hold = 1'b0;
        end
        prev_scl = scl_i;
        prev_oe  = scl_oe_o;
        // target update
        if (scl_oe_o) hold_cnt = stretch_len;
        else if (hold_cnt > 0) hold_cnt--;
        tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        tick_i   = (tick_div <= 1) ? 1'b1 : (tick_cnt == 0);
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic setup(input int rel, input int str, input bit stuck, input int div);
        @(negedge clk);
        release_after = rel;
        stretch_len   = str;
        scl_stuck     = stuck;
        tick_div      = div;
        rises         = 0;
        sda_hold      = (rel > 0);
        obs_pulses    = 0;
        sda_oe_seen   = 0;
        first_oe_at   = -1;
        last_oe_w     = 0;
        last_low_w    = 0;
        max_done_run  = 0;
    endtask

    // Issues a request and waits for the end-of-run strobe
    task automatic launch(input int extra_starts);
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1;
        since_start = 0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < extra_starts; k++) begin
            repeat (7) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int n = 0; n < 5000 && done_cnt == d0; n++) @(negedge clk);
        chk("R10", "one done strobe per run", done_cnt - d0, 1);
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1", "scl_oe after reset", int'(scl_oe_o), 0);
        chk("R1", "sda_oe after reset", int'(sda_oe_o), 0);
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "done after reset", int'(done_o), 0);
        chk("R1", "status after reset", int'(status_o), 0);
        chk("R1", "pulses after reset", int'(pulses_o), 0);
    endtask

    task automatic test_bus_free();
        setup(0, 0, 1'b0, 1);
        launch(0);
        chk("R4", "status bus free", int'(status_o), 0);
        chk("R4", "pulses bus free", int'(pulses_o), 0);
        chk("R4", "no pulse on line", obs_pulses, 0);
        chk("R2", "sda never pulled", sda_oe_seen, 0);
    endtask

    task automatic test_clock_held();
        setup(100, 0, 1'b1, 1);
        launch(0);
        chk("R3", "status clock held", int'(status_o), 1);
        chk("R3", "pulses clock held", int'(pulses_o), 0);
        chk("R3", "no pulse on line", obs_pulses, 0);
        setup(0, 0, 1'b0, 1);
    endtask

    task automatic test_freed_after(input int k);
        setup(k, 0, 1'b0, 1);
        launch(0);
        chk("R5", "status freed", int'(status_o), 0);
        chk("R5", "pulses reported", int'(pulses_o), k);
        chk("R5", "pulses on line", obs_pulses, k);
        chk("R7", "low width", last_oe_w, HALF);
        chk_range("R2", "release window before first pulse", first_oe_at, SETTLE + 1, 1000);
        chk("R2", "sda never pulled", sda_oe_seen, 0);
    endtask

    task automatic test_data_held();
        setup(100, 0, 1'b0, 1);
        launch(0);
        chk("R6", "status data held", int'(status_o), 2);
        chk("R6", "pulses at limit", int'(pulses_o), MAXP);
        chk("R6", "pulses on line", obs_pulses, MAXP);
    endtask

    task automatic test_stretch_ok();
        setup(2, 5, 1'b0, 1);
        launch(0);
        chk("R7", "status with stretch", int'(status_o), 0);
        chk("R7", "pulses with stretch", int'(pulses_o), 2);
        chk("R7", "line low width with stretch", last_low_w, HALF + 5);
    endtask

    task automatic test_stretch_timeout();
        setup(100, 40, 1'b0, 1);
        launch(0);
        chk("R8", "status stretch timeout", int'(status_o), 3);
        chk("R8", "pulses at timeout", int'(pulses_o), 1);
        chk("R8", "pulses on line", obs_pulses, 1);
        repeat (50) @(negedge clk);
        setup(0, 0, 1'b0, 1);
    endtask

    task automatic test_slow_tick();
        setup(1, 0, 1'b0, 4);
        launch(0);
        chk("R7", "status slow tick", int'(status_o), 0);
        chk_range("R7", "low width at tick/4", last_oe_w, (HALF - 1) * 4 + 1, HALF * 4);
        setup(0, 0, 1'b0, 1);
    endtask

    task automatic test_ignore_start();
        setup(5, 0, 1'b0, 1);
        launch(4);
        chk("R9", "status after extra starts", int'(status_o), 0);
        chk("R9", "pulses after extra starts", int'(pulses_o), 5);
        chk("R9", "pulses on line", obs_pulses, 5);
    endtask

    task automatic test_hold_results();
        int d0;
        setup(3, 0, 1'b0, 1);
        launch(0);
        d0 = done_cnt;
        repeat (30) @(negedge clk);
        chk("R10", "done width", max_done_run, 1);
        chk("R10", "no stray done", done_cnt - d0, 0);
        chk("R10", "status held", int'(status_o), 0);
        chk("R10", "pulses held", int'(pulses_o), 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_bus_free();
        test_clock_held();
        test_freed_after(3);
        test_freed_after(MAXP);
        test_data_held();
        test_stretch_ok();
        test_stretch_timeout();
        test_slow_tick();
        test_ignore_start();
        test_hold_results();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule